// File: doc/BRIEF.md
# Interrupt Take Arbiter with Virtual Masking

This block decides, every cycle, which asynchronous interrupt a processor core should take. It watches three physical request lines (IRQ, FIQ and asynchronous abort) and three virtual ones, and applies the masking rules for each. A virtual IRQ or FIQ is pending when its external line is high or when the hypervisor has set the matching injection bit. A virtual abort can only be injected by the hypervisor. The block then picks the single winner by a fixed interleaved priority. Reset and event requests are also inputs. They are never masked and count towards the "any" flag.

The virtual masking decision depends on:
- the security state and whether EL2 is enabled in secure state;
- the trap-general bit;
- the per-type routing bit;
- the current exception level;
- the PSTATE mask bits.

Physical requests are taken whenever their PSTATE mask bit is clear. The block also produces two more outputs. One is a wake-from-WFI flag. The other is a status word that shows the pending abort, IRQ and FIQ state as software would see it. Every output is registered, so results appear one clock after the inputs are sampled.

A parameter selects a legacy rule set for cores whose highest exception level runs in 32-bit state. In that mode, a set trap-general bit forces routing unless the host-extension bit is set on a core that supports it. Virtual requests are then masked in secure state and at EL2.

Top module: `irq_take_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, take_o, any_o, wake_o and status_o are all zero.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. Outputs do not change before that edge.
- R3: A physical IRQ, FIQ or abort request is takeable exactly when its PSTATE mask bit (I, F or A) is clear.
- R4: A virtual IRQ is pending when vline_irq_i or hv_vi_i is set, and a virtual FIQ when vline_fiq_i or hv_vf_i is set. A virtual abort is pending only through hv_va_i.
- R5: In secure state with secure EL2 disabled, no virtual request is taken.
- R6: When hv_tge_i is 1, or the routing bit for the type is 0, the virtual request of that type is not taken.
- R7: With hv_tge_i 0 and the routing bit 1, a virtual request is not taken at EL2 or EL3 (cur_el_i 2 or 3). At EL0 or EL1 it is taken only when its PSTATE mask bit is clear.
- R8: take_o is zero or one-hot. Its bit 0 is physical IRQ, bit 1 virtual IRQ, bit 2 physical FIQ, bit 3 virtual FIQ, bit 4 physical abort and bit 5 virtual abort. When several requests are takeable, the lowest bit index wins.
- R9: any_o is set when take_o is non-zero, or when reset_req_i or event_req_i is set, regardless of any mask.
- R10: status_o bit 8 reports abort, bit 7 IRQ and bit 6 FIQ. All other bits are zero. A bit shows the virtual pending state when cur_el_i < 2, EL2 is enabled (non-secure, or secure EL2 enabled) and that type's routing bit is set. Otherwise it shows the physical line.
- R11: wake_o is set by any pending physical IRQ, FIQ, abort, reset or event request, whatever the masks. It is also set by a pending virtual request whose routing bit is set while cur_el_i < 2 with EL2 enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phys_irq_i | input | 1 | Physical IRQ request |
| phys_fiq_i | input | 1 | Physical FIQ request |
| phys_abt_i | input | 1 | Physical asynchronous abort request |
| vline_irq_i | input | 1 | External virtual IRQ line |
| vline_fiq_i | input | 1 | External virtual FIQ line |
| reset_req_i | input | 1 | Reset request, never masked |
| event_req_i | input | 1 | Event request, never masked |
| hv_vi_i | input | 1 | Hypervisor virtual IRQ injection |
| hv_vf_i | input | 1 | Hypervisor virtual FIQ injection |
| hv_va_i | input | 1 | Hypervisor virtual abort injection |
| route_irq_i | input | 1 | IRQ routing-to-hypervisor bit |
| route_fiq_i | input | 1 | FIQ routing-to-hypervisor bit |
| route_abt_i | input | 1 | Abort routing-to-hypervisor bit |
| hv_tge_i | input | 1 | Trap-general bit |
| hv_e2h_i | input | 1 | Host-extension bit (legacy rules only) |
| sec_el2_en_i | input | 1 | EL2 enabled in secure state |
| secure_i | input | 1 | Core is in secure state |
| cur_el_i | input | 2 | Current exception level, 0 to 3 |
| mask_a_i | input | 1 | PSTATE abort mask |
| mask_i_i | input | 1 | PSTATE IRQ mask |
| mask_f_i | input | 1 | PSTATE FIQ mask |
| take_o | output | 6 | One-hot winner, priority order |
| any_o | output | 1 | Some interrupt to take, or reset/event pending |
| wake_o | output | 1 | Wake from wait-for-interrupt |
| status_o | output | STATUS_W | Pending status word |

## Verification
The assertions assume the default rule set, with the legacy parameter off. They also assume that the control inputs are steady across a clock edge, so that every `|=>` property compares the outputs with the inputs captured at the previous edge. The bench drives every input on the falling edge and clears all inputs between scenarios, so each check sees only the pattern its task set up. It holds each pattern for a full cycle before it samples at the next falling edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   // positions in the take vector, lowest index wins
   localparam int unsigned NUM_KIND  = 3;              // IRQ, FIQ, abort
   localparam int unsigned NUM_SRC   = 2 * NUM_KIND;   // physical + virtual each
   localparam int unsigned KIND_IRQ  = 0;
   localparam int unsigned KIND_FIQ  = 1;
   localparam int unsigned KIND_ABT  = 2;
   localparam int unsigned EL_W      = 2;

   typedef logic [EL_W-1:0] el_t;
   localparam el_t EL_HYP = el_t'(2);

   // physical source of kind k sits at 2k, virtual at 2k+1
   function automatic int unsigned phys_slot(int unsigned k);
      return 2 * k;
   endfunction
   function automatic int unsigned virt_slot(int unsigned k);
      return 2 * k + 1;
   endfunction
endpackage

// File: rtl/irq_virt_gate.sv
module irq_virt_gate
   import irq_arb_pkg::*;
#(
   parameter bit LEGACY_RULES = 1'b0,
   parameter bit HAS_VHE      = 1'b1
) (
   input  logic pend_i,
   input  logic route_i,
   input  logic pmask_i,
   input  logic tge_i,
   input  logic e2h_i,
   input  logic secure_i,
   input  logic sel2_en_i,
   input  el_t  el_i,
   output logic take_o
);
   logic below_hyp;
   logic a64_ok;
   logic leg_route;
   logic leg_ok;

   always_comb begin
      below_hyp = (el_i < EL_HYP);
      // 64-bit table: every masked row collapses to these terms
      a64_ok    = !(secure_i && !sel2_en_i) && !tge_i && route_i
                  && below_hyp && !pmask_i;
      // 32-bit table: trap-general forces routing unless host extension
      leg_route = tge_i ? (!HAS_VHE || !e2h_i) : route_i;
      leg_ok    = leg_route && !pmask_i && !secure_i && (el_i != EL_HYP);
      take_o    = pend_i && (LEGACY_RULES ? leg_ok : a64_ok);
   end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o
);
   if (N < 1) begin : g_bad
      $error("irq_prio_pick: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_slot
      if (i == 0) begin : g_top
         assign grant_o[i] = req_i[i];
      end else begin : g_rest
         assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
      end
   end
endmodule

// File: rtl/irq_status_view.sv
module irq_status_view
   import irq_arb_pkg::*;
#(
   parameter int unsigned STATUS_W = 32,
   parameter int unsigned ABT_BIT  = 8,
   parameter int unsigned IRQ_BIT  = 7,
   parameter int unsigned FIQ_BIT  = 6
) (
   input  logic [NUM_KIND-1:0] phys_i,
   input  logic [NUM_KIND-1:0] virt_i,
   input  logic [NUM_KIND-1:0] route_i,
   input  logic                guest_i,
   output logic [STATUS_W-1:0] status_o
);
   if (ABT_BIT >= STATUS_W || IRQ_BIT >= STATUS_W || FIQ_BIT >= STATUS_W) begin : g_bad_w
      $error("irq_status_view: status bit beyond STATUS_W");
   end
   if (ABT_BIT == IRQ_BIT || IRQ_BIT == FIQ_BIT || ABT_BIT == FIQ_BIT) begin : g_bad_pos
      $error("irq_status_view: status bits must be distinct");
   end

   logic [NUM_KIND-1:0] shown;

   for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
      assign shown[k] = (guest_i && route_i[k]) ? virt_i[k] : phys_i[k];
   end

   always_comb begin
      status_o          = '0;
      status_o[ABT_BIT] = shown[KIND_ABT];
      status_o[IRQ_BIT] = shown[KIND_IRQ];
      status_o[FIQ_BIT] = shown[KIND_FIQ];
   end
endmodule

// File: rtl/irq_take_arbiter.sv
module irq_take_arbiter
   import irq_arb_pkg::*;
#(
   parameter bit          LEGACY_RULES = 1'b0,
   parameter bit          HAS_VHE      = 1'b1,
   parameter int unsigned STATUS_W     = 32
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                phys_irq_i,
   input  logic                phys_fiq_i,
   input  logic                phys_abt_i,
   input  logic                vline_irq_i,
   input  logic                vline_fiq_i,
   input  logic                reset_req_i,
   input  logic                event_req_i,
   input  logic                hv_vi_i,
   input  logic                hv_vf_i,
   input  logic                hv_va_i,
   input  logic                route_irq_i,
   input  logic                route_fiq_i,
   input  logic                route_abt_i,
   input  logic                hv_tge_i,
   input  logic                hv_e2h_i,
   input  logic                sec_el2_en_i,
   input  logic                secure_i,
   input  logic [1:0]          cur_el_i,
   input  logic                mask_a_i,
   input  logic                mask_i_i,
   input  logic                mask_f_i,
   output logic [5:0]          take_o,
   output logic                any_o,
   output logic                wake_o,
   output logic [STATUS_W-1:0] status_o
);
   localparam int unsigned SRC_N = NUM_SRC;

   if (SRC_N != 6) begin : g_bad_src
      $error("irq_take_arbiter: take vector is six wide");
   end

   logic [NUM_KIND-1:0] p_pend, v_pend, route, pmask;
   logic [SRC_N-1:0]    req, grant;
   logic                el2_on, guest;
   logic                any_d, wake_d;
   logic [STATUS_W-1:0] status_d;

   assign p_pend = {phys_abt_i, phys_fiq_i, phys_irq_i};
   assign v_pend = {hv_va_i, (vline_fiq_i | hv_vf_i), (vline_irq_i | hv_vi_i)};
   assign route  = {route_abt_i, route_fiq_i, route_irq_i};
   assign pmask  = {mask_a_i, mask_f_i, mask_i_i};
   assign el2_on = !secure_i || sec_el2_en_i;
   assign guest  = (cur_el_i < EL_HYP) && el2_on;

   for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
      assign req[phys_slot(k)] = p_pend[k] & ~pmask[k];
      irq_virt_gate #(
         .LEGACY_RULES(LEGACY_RULES),
         .HAS_VHE     (HAS_VHE)
      ) u_vgate (
         .pend_i   (v_pend[k]),
         .route_i  (route[k]),
         .pmask_i  (pmask[k]),
         .tge_i    (hv_tge_i),
         .e2h_i    (hv_e2h_i),
         .secure_i (secure_i),
         .sel2_en_i(sec_el2_en_i),
         .el_i     (cur_el_i),
         .take_o   (req[virt_slot(k)])
      );
   end

   irq_prio_pick #(.N(SRC_N)) u_pick (
      .req_i  (req),
      .grant_o(grant)
   );

   irq_status_view #(.STATUS_W(STATUS_W)) u_view (
      .phys_i  (p_pend),
      .virt_i  (v_pend),
      .route_i (route),
      .guest_i (guest),
      .status_o(status_d)
   );

   assign any_d  = (|grant) | reset_req_i | event_req_i;
   assign wake_d = (|p_pend) | reset_req_i | event_req_i
                   | ((|(v_pend & route)) & guest);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         take_o   <= '0;
         any_o    <= 1'b0;
         wake_o   <= 1'b0;
         status_o <= '0;
      end else begin
         take_o   <= grant;
         any_o    <= any_d;
         wake_o   <= wake_d;
         status_o <= status_d;
      end
   end
endmodule

// File: rtl/irq_take_arbiter_chk.sv
module irq_take_arbiter_chk #(
   parameter bit LEGACY_RULES = 1'b0
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       phys_irq_i,
   input logic       reset_req_i,
   input logic       event_req_i,
   input logic       hv_tge_i,
   input logic       sec_el2_en_i,
   input logic       secure_i,
   input logic [1:0] cur_el_i,
   input logic       mask_i_i,
   input logic [5:0] take_o,
   input logic       any_o,
   input logic       wake_o
);
   // R8
   take_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(take_o));

   // R8
   irq_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phys_irq_i && !mask_i_i) |=> (take_o == 6'b000001));

   // R5
   secure_virt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!LEGACY_RULES && secure_i && !sec_el2_en_i) |=> (take_o[1] == 1'b0 && take_o[3] == 1'b0 && take_o[5] == 1'b0));

   // R6
   tge_virt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!LEGACY_RULES && hv_tge_i) |=> (take_o[1] == 1'b0 && take_o[3] == 1'b0 && take_o[5] == 1'b0));

   // R7
   high_el_virt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!LEGACY_RULES && cur_el_i >= 2'd2) |=> (take_o[1] == 1'b0 && take_o[3] == 1'b0 && take_o[5] == 1'b0));

   // R9
   unmaskable_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reset_req_i || event_req_i) |=> any_o);

   // R11
   phys_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phys_irq_i |=> wake_o);
endmodule

bind irq_take_arbiter irq_take_arbiter_chk #(.LEGACY_RULES(LEGACY_RULES)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .phys_irq_i  (phys_irq_i),
   .reset_req_i (reset_req_i),
   .event_req_i (event_req_i),
   .hv_tge_i    (hv_tge_i),
   .sec_el2_en_i(sec_el2_en_i),
   .secure_i    (secure_i),
   .cur_el_i    (cur_el_i),
   .mask_i_i    (mask_i_i),
   .take_o      (take_o),
   .any_o       (any_o),
   .wake_o      (wake_o)
);

// File: tb/irq_take_arbiter_tb.sv
module irq_take_arbiter_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic p_irq, p_fiq, p_abt, vl_irq, vl_fiq, r_req, e_req;
   logic vi, vf, va, ro_i, ro_f, ro_a, tge, e2h, sel2, sec;
   logic [1:0] el;
   logic m_a, m_i, m_f;
   logic [5:0]  take;
   logic        any, wake;
   logic [31:0] status;
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_take_arbiter u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .phys_irq_i(p_irq), .phys_fiq_i(p_fiq), .phys_abt_i(p_abt),
      .vline_irq_i(vl_irq), .vline_fiq_i(vl_fiq),
      .reset_req_i(r_req), .event_req_i(e_req),
      .hv_vi_i(vi), .hv_vf_i(vf), .hv_va_i(va),
      .route_irq_i(ro_i), .route_fiq_i(ro_f), .route_abt_i(ro_a),
      .hv_tge_i(tge), .hv_e2h_i(e2h), .sec_el2_en_i(sel2), .secure_i(sec),
      .cur_el_i(el), .mask_a_i(m_a), .mask_i_i(m_i), .mask_f_i(m_f),
      .take_o(take), .any_o(any), .wake_o(wake), .status_o(status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      {p_irq, p_fiq, p_abt, vl_irq, vl_fiq, r_req, e_req} = '0;
      {vi, vf, va, ro_i, ro_f, ro_a, tge, e2h, sel2, sec} = '0;
      el = 2'd1;
      {m_a, m_i, m_f} = '0;
   endtask

   // inputs set at a falling edge are captured at the next rising edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      idle();
      p_irq = 1'b1; r_req = 1'b1; vi = 1'b1; ro_i = 1'b1;
      repeat (3) step();
      chk("R1 take in reset", 32'(take), 32'h0);
      chk("R1 any in reset", 32'(any), 32'h0);
      chk("R1 wake in reset", 32'(wake), 32'h0);
      chk("R1 status in reset", status, 32'h0);
      idle();
      rst_n = 1'b1;
      step();
      chk("R1 first cycle after reset", {26'(take), any, wake, 4'(status[8:6])}, 32'h0);
   endtask

   task automatic t_latency();
      idle(); step();
      p_fiq = 1'b1;
      #1 chk("R2 no change before edge", 32'(take), 32'h0);
      step();
      chk("R2 after one edge", 32'(take), 32'h04);
   endtask

   task automatic t_phys();
      idle(); p_irq = 1'b1; step();
      chk("R3 phys irq taken", 32'(take), 32'h01);
      m_i = 1'b1; step();
      chk("R3 phys irq masked", 32'(take), 32'h0);
      chk("R9 nothing to take", 32'(any), 32'h0);
      idle(); p_abt = 1'b1; m_a = 1'b1; p_fiq = 1'b1; step();
      chk("R3 abort masked fiq taken", 32'(take), 32'h04);
   endtask

   task automatic t_virt_pend();
      idle(); ro_i = 1'b1; vl_irq = 1'b1; step();
      chk("R4 virt irq by line", 32'(take), 32'h02);
      vl_irq = 1'b0; vi = 1'b1; step();
      chk("R4 virt irq by inject", 32'(take), 32'h02);
      idle(); ro_f = 1'b1; vl_fiq = 1'b1; step();
      chk("R4 virt fiq by line", 32'(take), 32'h08);
      idle(); ro_a = 1'b1; va = 1'b1; step();
      chk("R4 virt abort by inject", 32'(take), 32'h20);
   endtask

   task automatic t_secure();
      idle(); ro_i = 1'b1; vi = 1'b1; sec = 1'b1; step();
      chk("R5 secure no sel2 masks", 32'(take), 32'h0);
      sel2 = 1'b1; step();
      chk("R5 secure with sel2 takes", 32'(take), 32'h02);
   endtask

   task automatic t_route();
      idle(); ro_i = 1'b1; vi = 1'b1; tge = 1'b1; step();
      chk("R6 tge masks", 32'(take), 32'h0);
      tge = 1'b0; ro_i = 1'b0; step();
      chk("R6 route clear masks", 32'(take), 32'h0);
   endtask

   task automatic t_level();
      idle(); ro_f = 1'b1; vf = 1'b1; el = 2'd2; step();
      chk("R7 masked at EL2", 32'(take), 32'h0);
      el = 2'd3; step();
      chk("R7 masked at EL3", 32'(take), 32'h0);
      el = 2'd0; m_f = 1'b1; step();
      chk("R7 pstate mask at EL0", 32'(take), 32'h0);
      m_f = 1'b0; step();
      chk("R7 taken at EL0", 32'(take), 32'h08);
   endtask

   task automatic t_prio();
      idle();
      {p_irq, p_fiq, p_abt, vi, vf, va, ro_i, ro_f, ro_a} = '1;
      step(); chk("R8 phys irq first", 32'(take), 32'h01);
      p_irq = 1'b0; step(); chk("R8 virt irq second", 32'(take), 32'h02);
      vi = 1'b0; step(); chk("R8 phys fiq third", 32'(take), 32'h04);
      p_fiq = 1'b0; step(); chk("R8 virt fiq fourth", 32'(take), 32'h08);
      vf = 1'b0; step(); chk("R8 phys abort fifth", 32'(take), 32'h10);
      p_abt = 1'b0; step(); chk("R8 virt abort last", 32'(take), 32'h20);
   endtask

   task automatic t_any();
      idle(); {m_a, m_i, m_f} = '1; r_req = 1'b1; step();
      chk("R9 reset request any", {31'(take), any}, 32'h1);
      r_req = 1'b0; e_req = 1'b1; step();
      chk("R9 event request any", {31'(take), any}, 32'h1);
   endtask

   task automatic t_status();
      idle(); ro_i = 1'b1; vi = 1'b1; step();
      chk("R10 irq shows virtual", status, 32'h080);
      ro_i = 1'b0; step();
      chk("R10 irq shows physical", status, 32'h0);
      idle(); ro_f = 1'b1; p_fiq = 1'b1; step();
      chk("R10 fiq shows virtual", status, 32'h0);
      el = 2'd2; step();
      chk("R10 fiq physical at EL2", status, 32'h040);
      idle(); ro_a = 1'b1; va = 1'b1; sec = 1'b1; sel2 = 1'b1; step();
      chk("R10 abort virtual secure el2", status, 32'h100);
      sel2 = 1'b0; step();
      chk("R10 abort physical el2 off", status, 32'h0);
   endtask

   task automatic t_wake();
      idle(); ro_i = 1'b1; vi = 1'b1; m_i = 1'b1; step();
      chk("R11 masked virt wakes", {30'(take), wake, any}, 32'h2);
      el = 2'd2; step();
      chk("R11 no wake at EL2", 32'(wake), 32'h0);
      el = 2'd1; ro_i = 1'b0; step();
      chk("R11 no wake unrouted", 32'(wake), 32'h0);
      idle(); p_abt = 1'b1; m_a = 1'b1; step();
      chk("R11 masked phys wakes", 32'(wake), 32'h1);
   endtask

   initial begin
      idle();
      @(negedge clk);
      t_reset();
      t_latency();
      t_phys();
      t_virt_pend();
      t_secure();
      t_route();
      t_level();
      t_prio();
      t_any();
      t_status();
      t_wake();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule